// File: doc/BRIEF.md
# Power-Management Event Status and Enable Registers

This block turns slow external event pins into software-visible sticky status bits and raises power-management requests from them. Nine general-purpose inputs each have a status bit and an enable bit. An enabled, set status bit drives both the system-control interrupt (`sci`) and the wake request (`wake`). A thermal pin has its own status bit. That bit is set only while thermal detection is enabled and the pin sits at the level chosen by `therm_pol`. A control bit steers the thermal event to `sci` or to the system-management interrupt (`smi`). An NMI input can also drive `sci` when its enable bit is set.

Software reaches the registers over a plain synchronous bus: address, write data, write strobe, read strobe and registered read data. The bus has no valid/ready handshake and no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. A read returns data on the edge after `bus_rd`, and `bus_rdata` holds that value until the next read.

There are two resets. A warm reset clears everything except the general-purpose enable register. A cold reset clears everything.

Top module: `pm_evt_regs`

## Requirements
- R1: After a cold reset, every register reads 0x0000 and `sci`, `smi` and `wake` are low.
- R2: Each GPIO input passes through two synchronizer flops. When it is high, status bit i at word offset 0 is set on the third rising edge after the input goes high, and the bit stays set after the input falls.
- R3: A write to offset 0 clears each status bit written with 1. Bits written with 0 are unchanged. The thermal status (bit 0 at offset 3) is cleared the same way.
- R4: When an input is still high during a clearing write to its status bit, the bit stays set.
- R5: `wake` is the OR of (status AND enable) over the nine GPIO bits, with enable at offset 1. `sci` includes the same term. Both fall once software clears the enabled set bits.
- R6: A warm reset clears status, control and read data but leaves the enable register unchanged. Only a cold reset clears the enable register. Bus writes are ignored while either reset is asserted.
- R7: Reserved bits read as 0 and ignore writes. These are bits 15:9 at offsets 0 and 1, bits 15:3 at offset 2, and bits 15:1 at offset 3.
- R8: The control register sits at offset 2, with thermal enable at bit 0. While thermal enable is 1, the synchronized thermal input at its active level sets thermal status on the third edge. The active level is high when `therm_pol`=1 and low when `therm_pol`=0. While thermal enable is 0, the thermal input has no effect.
- R9: Control bit 2 is the route bit. With route=1, a set and enabled thermal status drives `smi` and not `sci`. With route=0, it drives `sci` and not `smi`.
- R10: Control bit 1 is the NMI enable. While it is 1, `nmi_in` high drives `sci` combinationally. While it is 0, `nmi_in` has no effect.
- R11: `bus_rdata` is registered. It shows the addressed register on the edge after `bus_rd` and holds between reads. Offsets 4 to 7 read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Power-on reset, active low, clears all state |
| rst_warm_n | input | 1 | Soft reset, active low, keeps the GPIO enable register |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| gpio_in | input | 9 | Asynchronous general-purpose event inputs |
| therm_in | input | 1 | Asynchronous thermal event input |
| therm_pol | input | 1 | Thermal active level (1 = high) |
| nmi_in | input | 1 | NMI event input |
| sci | output | 1 | System-control interrupt request, level |
| smi | output | 1 | System-management interrupt request, level |
| wake | output | 1 | Wake request, level |

## Verification
The hardest case to reach is a clearing write to a status bit while its input is still high. The two synchronizer stages mean the input must be raised three cycles early and held through the write edge. The bench does this on purpose for one GPIO bit. It then runs a long random phase that changes the inputs every cycle, mixed with warm and cold resets, so that set and clear collide often. A behavioural reference model checks every cycle, and a warm reset with nonzero enables checks R6.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W   = 16;
  localparam int GP_BITS = 9;
  localparam int BUS_AW  = 3;

  localparam int OFS_GP_STS = 0;
  localparam int OFS_GP_EN  = 1;
  localparam int OFS_CTL    = 2;
  localparam int OFS_TH_STS = 3;

  localparam int CTL_W = 3;

  typedef struct packed {
    logic route_smi;
    logic nmi_en;
    logic therm_en;
  } ctl_t;
endpackage

// File: rtl/pm_evt_sync.sv
module pm_evt_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/pm_evt_gp_bank.sv
module pm_evt_gp_bank #(
  parameter int GP_W = 9
) (
  input  logic            clk,
  input  logic            rst_any_n,
  input  logic            rst_cold_n,
  input  logic            wr_sts,
  input  logic            wr_en,
  input  logic [GP_W-1:0] wdata,
  input  logic [GP_W-1:0] lvl,
  output logic [GP_W-1:0] sts,
  output logic [GP_W-1:0] en
);
  for (genvar i = 0; i < GP_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_any_n) begin
      if (!rst_any_n)   sts[i] <= 1'b0;
      else if (lvl[i])  sts[i] <= 1'b1;
      else if (wr_sts && wdata[i]) sts[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_cold_n) begin
      if (!rst_cold_n)  en[i] <= 1'b0;
      else if (wr_en)   en[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/pm_evt_therm.sv
module pm_evt_therm
  import pm_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_any_n,
  input  logic wr_ctl,
  input  logic wr_clr,
  input  ctl_t ctl_wdata,
  input  logic clr_bit,
  input  logic lvl,
  input  logic pol,
  output ctl_t ctl,
  output logic th_sts
);
  logic active;
  assign active = pol ? lvl : ~lvl;

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n)  ctl <= '0;
    else if (wr_ctl) ctl <= ctl_wdata;
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n)                      th_sts <= 1'b0;
    else if (ctl.therm_en && active)     th_sts <= 1'b1;
    else if (wr_clr && clr_bit)          th_sts <= 1'b0;
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int GP_W   = GP_BITS,
  parameter int ADDR_W = BUS_AW
) (
  input  logic              clk,
  input  logic              rst_cold_n,
  input  logic              rst_warm_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [GP_W-1:0]   gpio_in,
  input  logic              therm_in,
  input  logic              therm_pol,
  input  logic              nmi_in,
  output logic              sci,
  output logic              smi,
  output logic              wake
);
  localparam int SYNC_W = GP_W + 1;

  logic              rst_any_n;
  logic              wr_ok;
  logic [SYNC_W-1:0] sync_q;
  logic [GP_W-1:0]   gp_s2, gp_sts, gp_en;
  logic              th_s2, th_sts;
  ctl_t              ctl;
  logic              route;
  logic [REG_W-1:0]  rd_next;
  logic              gp_hit, th_hit;

  assign rst_any_n = rst_cold_n & rst_warm_n;
  assign wr_ok     = bus_wr & rst_any_n;

  pm_evt_sync #(.W(SYNC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_any_n),
    .d_async ({therm_in, gpio_in}),
    .q_sync  (sync_q)
  );
  assign gp_s2 = sync_q[GP_W-1:0];
  assign th_s2 = sync_q[GP_W];

  pm_evt_gp_bank #(.GP_W(GP_W)) u_gp (
    .clk        (clk),
    .rst_any_n  (rst_any_n),
    .rst_cold_n (rst_cold_n),
    .wr_sts     (wr_ok && bus_addr == ADDR_W'(OFS_GP_STS)),
    .wr_en      (wr_ok && bus_addr == ADDR_W'(OFS_GP_EN)),
    .wdata      (bus_wdata[GP_W-1:0]),
    .lvl        (gp_s2),
    .sts        (gp_sts),
    .en         (gp_en)
  );

  pm_evt_therm u_th (
    .clk       (clk),
    .rst_any_n (rst_any_n),
    .wr_ctl    (wr_ok && bus_addr == ADDR_W'(OFS_CTL)),
    .wr_clr    (wr_ok && bus_addr == ADDR_W'(OFS_TH_STS)),
    .ctl_wdata (ctl_t'(bus_wdata[CTL_W-1:0])),
    .clr_bit   (bus_wdata[0]),
    .lvl       (th_s2),
    .pol       (therm_pol),
    .ctl       (ctl),
    .th_sts    (th_sts)
  );
  assign route = ctl.route_smi;

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      ADDR_W'(OFS_GP_STS): rd_next[GP_W-1:0]  = gp_sts;
      ADDR_W'(OFS_GP_EN):  rd_next[GP_W-1:0]  = gp_en;
      ADDR_W'(OFS_CTL):    rd_next[CTL_W-1:0] = ctl;
      ADDR_W'(OFS_TH_STS): rd_next[0]         = th_sts;
      default:             rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n)  bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign gp_hit = |(gp_sts & gp_en);
  assign th_hit = th_sts & ctl.therm_en;
  assign wake   = gp_hit;
  assign sci    = gp_hit | (th_hit & ~route) | (ctl.nmi_en & nmi_in);
  assign smi    = th_hit & route;
endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk #(
  parameter int GP_W = 9
) (
  input logic            clk,
  input logic            rst_cold_n,
  input logic            rst_warm_n,
  input logic [15:0]     bus_rdata,
  input logic            sci,
  input logic            smi,
  input logic            wake,
  input logic [GP_W-1:0] gp_s2,
  input logic [GP_W-1:0] gp_sts,
  input logic [GP_W-1:0] gp_en,
  input logic            route
);
  AST_ENABLE_KEEP_WARM: assert property (@(posedge clk) disable iff (!rst_cold_n)
    !rst_warm_n |=> $stable(gp_en)); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    1'b1 |=> ((gp_sts & $past(gp_s2)) == $past(gp_s2))); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    1'b1 |=> ((gp_sts & ~$past(gp_sts) & ~$past(gp_s2)) == '0)); // R2
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    bus_rdata[15:9] == 7'd0); // R7
  AST_SMI_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    smi |-> route); // R9
  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (gp_en == '0) |-> !wake); // R5
endmodule

bind pm_evt_regs pm_evt_regs_chk #(.GP_W(GP_W)) u_chk (
  .clk        (clk),
  .rst_cold_n (rst_cold_n),
  .rst_warm_n (rst_warm_n),
  .bus_rdata  (bus_rdata),
  .sci        (sci),
  .smi        (smi),
  .wake       (wake),
  .gp_s2      (gp_s2),
  .gp_sts     (gp_sts),
  .gp_en      (gp_en),
  .route      (route)
);

// File: tb/tb_pm_evt_regs.sv
`timescale 1ns/1ps
module tb_pm_evt_regs;
  logic        clk = 1'b0;
  logic        rst_cold_n = 1'b0, rst_warm_n = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic [8:0]  gpio_in = '0;
  logic        therm_in = 1'b0, therm_pol = 1'b1, nmi_in = 1'b0;
  logic        sci, smi, wake;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pm_evt_regs dut (.*);

  // behavioural reference state
  logic [8:0]  m_g1, m_g2, m_sts, m_en;
  logic        m_t1, m_t2, m_tsts;
  logic [2:0]  m_ctl;
  logic [15:0] m_rd;

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {7'd0, m_sts};
      3'd1: return {7'd0, m_en};
      3'd2: return {13'd0, m_ctl};
      3'd3: return {15'd0, m_tsts};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_cold_n || !rst_warm_n) begin
      m_g1 = '0; m_g2 = '0; m_sts = '0; m_t1 = 0; m_t2 = 0;
      m_tsts = 0; m_ctl = '0; m_rd = '0;
      if (!rst_cold_n) m_en = '0;
    end else begin
      logic [15:0] rd_v;
      logic [8:0]  n_sts, n_en;
      logic [2:0]  n_ctl;
      logic        n_tsts, act;
      rd_v  = m_read(bus_addr);
      n_sts = m_sts; n_en = m_en; n_ctl = m_ctl; n_tsts = m_tsts;
      if (bus_wr && bus_addr == 3'd0) n_sts = n_sts & ~bus_wdata[8:0];
      if (bus_wr && bus_addr == 3'd1) n_en  = bus_wdata[8:0];
      if (bus_wr && bus_addr == 3'd2) n_ctl = bus_wdata[2:0];
      if (bus_wr && bus_addr == 3'd3 && bus_wdata[0]) n_tsts = 1'b0;
      n_sts = n_sts | m_g2;
      act = therm_pol ? m_t2 : ~m_t2;
      if (m_ctl[0] && act) n_tsts = 1'b1;
      if (bus_rd) m_rd = rd_v;
      m_g2 = m_g1; m_g1 = gpio_in; m_t2 = m_t1; m_t1 = therm_in;
      m_sts = n_sts; m_en = n_en; m_ctl = n_ctl; m_tsts = n_tsts;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done && rst_cold_n && rst_warm_n && cycles > 2) begin
      logic ex_gp, ex_th;
      ex_gp = |(m_sts & m_en);
      ex_th = m_tsts & m_ctl[0];
      chk("R11 rdata", bus_rdata, m_rd);
      chk("R5 wake", {15'd0, wake}, {15'd0, ex_gp});
      chk("R9 sci", {15'd0, sci}, {15'd0, ex_gp | (ex_th & ~m_ctl[2]) | (m_ctl[1] & nmi_in)});
      chk("R9 smi", {15'd0, smi}, {15'd0, ex_th & m_ctl[2]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); #1;
    bus_rd = 1; bus_addr = a;
    @(negedge clk); #1;
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic do_reset(input bit cold);
    @(negedge clk); #1;
    if (cold) rst_cold_n = 0; else rst_warm_n = 0;
    tick(3);
    rst_cold_n = 1; rst_warm_n = 1;
  endtask

  initial begin
    logic [15:0] v;
    tick(3);
    rst_cold_n = 1;
    tick(2);
    // R1: reset state
    rd(3'd0, v); chk("R1 gp status", v, 16'h0);
    rd(3'd1, v); chk("R1 gp enable", v, 16'h0);
    rd(3'd2, v); chk("R1 control", v, 16'h0);
    chk("R1 outputs", {13'd0, sci, smi, wake}, 16'h0);
    // R7: reserved bits
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R7 enable rsvd", v, 16'h01FF);
    wr(3'd2, 16'hFFF8); rd(3'd2, v); chk("R7 control rsvd", v, 16'h0000);
    // R2 / R5
    wr(3'd1, 16'h0005);
    gpio_in = 9'h001; tick(4);
    rd(3'd0, v); chk("R2 status set", v, 16'h0001);
    chk("R5 sci+wake", {14'd0, sci, wake}, 16'h0003);
    gpio_in = 9'h002; tick(1); gpio_in = 9'h000; tick(4);
    rd(3'd0, v); chk("R2 sticky", v, 16'h0003);
    // R3
    wr(3'd0, 16'h0000); rd(3'd0, v); chk("R3 write 0 no effect", v, 16'h0003);
    wr(3'd0, 16'h0001); rd(3'd0, v); chk("R3 W1C", v, 16'h0002);
    chk("R5 deassert", {14'd0, sci, wake}, 16'h0000);
    // R4: set wins over clear
    gpio_in = 9'h004; tick(4);
    wr(3'd0, 16'h0004); rd(3'd0, v); chk("R4 set wins", v, 16'h0006);
    gpio_in = 9'h000; tick(4);
    wr(3'd0, 16'h01FF); rd(3'd0, v); chk("R3 clear all", v, 16'h0000);
    // R6
    gpio_in = 9'h001; tick(1); gpio_in = 9'h000; tick(4);
    wr(3'd2, 16'h0003);
    do_reset(0); tick(1);
    rd(3'd1, v); chk("R6 enable kept", v, 16'h0005);
    rd(3'd0, v); chk("R6 status cleared", v, 16'h0000);
    rd(3'd2, v); chk("R6 control cleared", v, 16'h0000);
    do_reset(1); tick(1);
    rd(3'd1, v); chk("R6 cold clears enable", v, 16'h0000);
    // R8
    therm_pol = 1; therm_in = 1; tick(4);
    rd(3'd3, v); chk("R8 ignored when disabled", v, 16'h0000);
    wr(3'd2, 16'h0001); tick(3);
    rd(3'd3, v); chk("R8 active high sets", v, 16'h0001);
    chk("R9 route sci", {14'd0, sci, smi}, 16'h0002);
    therm_in = 0; tick(4);
    wr(3'd3, 16'h0001); rd(3'd3, v); chk("R3 thermal clear", v, 16'h0000);
    therm_pol = 0; tick(4);
    rd(3'd3, v); chk("R8 active low sets", v, 16'h0001);
    // R9
    wr(3'd2, 16'h0005); tick(1);
    chk("R9 route smi", {14'd0, sci, smi}, 16'h0001);
    therm_pol = 1; tick(4); wr(3'd3, 16'h0001);
    // R10
    wr(3'd2, 16'h0002); nmi_in = 1; tick(1);
    chk("R10 nmi sci", {15'd0, sci}, 16'h0001);
    wr(3'd2, 16'h0000); tick(1);
    chk("R10 nmi disabled", {15'd0, sci}, 16'h0000);
    nmi_in = 0;
    // R11
    rd(3'd5, v); chk("R11 unmapped", v, 16'h0000);
    wr(3'd1, 16'h0011); rd(3'd1, v); tick(3);
    chk("R11 hold", bus_rdata, 16'h0011);
    // random phase, reference compared every cycle
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      gpio_in   = 9'($urandom);
      therm_in  = 1'($urandom);
      therm_pol = ($urandom % 16) == 0 ? ~therm_pol : therm_pol;
      nmi_in    = 1'($urandom);
      bus_wr    = ($urandom % 3) == 0;
      bus_rd    = ($urandom % 2) == 0;
      bus_addr  = 3'($urandom);
      bus_wdata = 16'($urandom);
      rst_warm_n = ($urandom % 300) != 0;
      rst_cold_n = ($urandom % 900) != 0;
    end
    @(negedge clk); #1;
    bus_wr = 0; bus_rd = 0; rst_warm_n = 1; rst_cold_n = 1;
    tick(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule